// File: doc/BRIEF.md
# Line Interface Loopback Mode Controller

This block decides which loopback a line transceiver runs in and steers the transmit and receive data paths to match. The loopback command comes from one of two sources. In host mode, three register bits enable remote loop, local loop and network-loop code detection. In hardware mode, a three-level remote-loop pin is used together with a two-level local-loop pin. A separate flag from the network-loop code detector asks for network loopback. That flag only counts when detection is enabled and no remote loop is commanded.

The decided mode is held in a register that updates only on a clock edge. The data path multiplexers work from that register, so the transmit selection never changes between edges. In the remote-type modes (remote, network and dual), the recovered receive data and clock go out the line side in place of the local transmit inputs, and a bypass select is raised for the line encoder and decoder. In the local-type modes (local and dual), the local transmit data and clock are returned to the receive outputs.

Top module: `lb_ctrl`

## Requirements
- R1: While rst_ni is low, mode_o is 0 (none), codec_bypass_o is 0, the line outputs carry the transmit inputs and the receive outputs carry the receive inputs.
- R2: When host_mode_i is 1, reg_rloop_en_i=1 with reg_lloop_en_i=0 gives mode_o=1 (remote) after the next clock edge.
- R3: When host_mode_i is 0, pin_rloop_lvl_i=2'b10 (high) gives mode_o=1 (remote). A level of 2'b00 (low) with pin_lloop_i=0 gives mode_o=0.
- R4: When host_mode_i is 0, pin_rloop_lvl_i=2'b01 (midrange) enables network-loop detection and does not command remote loop. The code 2'b11 behaves as low.
- R5: mode_o=2 (network) when detection is enabled, nloop_flag_i=1 and no remote loop is commanded. With detection disabled, nloop_flag_i has no effect on mode_o. A remote command takes priority over network loop.
- R6: In modes 1, 2 and 4, line_data_o equals rx_data_i, line_clk_o equals rx_clk_i and codec_bypass_o is 1. The transmit inputs have no effect on the line outputs.
- R7: In modes 0, 1 and 2, rx_data_o and rx_clk_o follow rx_data_i and rx_clk_i.
- R8: A remote or network loop combined with a local loop gives mode_o=4 (dual). In that mode rx_data_o equals tx_data_i and rx_clk_o equals tx_clk_i.
- R9: A local loop alone gives mode_o=3. rx_data_o equals tx_data_i, the line outputs carry the transmit inputs and codec_bypass_o is 0.
- R10: host_mode_i selects the command source. The register bits are ignored in hardware mode and the pins are ignored in host mode.
- R11: mode_o changes only at a rising clk_i edge, one edge after the commanding inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_mode_i | input | 1 | 1 = register control, 0 = pin control |
| reg_rloop_en_i | input | 1 | Register remote-loop enable |
| reg_lloop_en_i | input | 1 | Register local-loop enable |
| reg_nloop_det_en_i | input | 1 | Register network-loop detection enable |
| pin_rloop_lvl_i | input | 2 | Three-level remote pin: 00 low, 01 mid, 10 high, 11 low |
| pin_lloop_i | input | 1 | Local-loop pin |
| nloop_flag_i | input | 1 | Network-loop request from the code detector |
| tx_clk_i | input | 1 | Local transmit clock |
| tx_data_i | input | DATA_W | Local transmit data |
| rx_clk_i | input | 1 | Recovered receive clock |
| rx_data_i | input | DATA_W | Recovered receive data |
| line_clk_o | output | 1 | Clock toward the line driver |
| line_data_o | output | DATA_W | Data toward the line driver |
| rx_clk_o | output | 1 | Receive clock output |
| rx_data_o | output | DATA_W | Receive data output |
| codec_bypass_o | output | 1 | Bypass select for the line encoder and decoder |
| mode_o | output | 3 | Active mode: 0 none, 1 remote, 2 network, 3 local, 4 dual |

## Verification
The bench builds the block with DATA_W=2 and gives transmit and receive data different bit patterns. A swapped or stuck bit lane in either path multiplexer therefore shows up at the ports. Two bits are enough to see every per-bit select. All five modes can be reached from both command sources, including the invalid pin code and the network-plus-local combination.

// File: rtl/lb_ctrl_pkg.sv
package lb_ctrl_pkg;
  typedef enum logic [2:0] {
    MODE_NONE    = 3'd0,
    MODE_REMOTE  = 3'd1,
    MODE_NETWORK = 3'd2,
    MODE_LOCAL   = 3'd3,
    MODE_DUAL    = 3'd4
  } lb_mode_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  function automatic logic is_remote_type(lb_mode_e m);
    return (m == MODE_REMOTE) || (m == MODE_NETWORK) || (m == MODE_DUAL);
  endfunction

  function automatic logic is_local_type(lb_mode_e m);
    return (m == MODE_LOCAL) || (m == MODE_DUAL);
  endfunction
endpackage

// File: rtl/lb_pin_decode.sv
module lb_pin_decode
  import lb_ctrl_pkg::*;
(
  input  logic [1:0] lvl_i,
  output logic       hi_o,
  output logic       mid_o
);
  always_comb begin
    hi_o  = 1'b0;
    mid_o = 1'b0;
    case (lvl_i)
      LVL_HIGH: hi_o  = 1'b1;
      LVL_MID:  mid_o = 1'b1;
      default:  ;  // low and the unused code both mean inactive
    endcase
  end
endmodule

// File: rtl/lb_mode_sel.sv
module lb_mode_sel
  import lb_ctrl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     host_mode_i,
  input  logic     reg_rloop_en_i,
  input  logic     reg_lloop_en_i,
  input  logic     reg_nloop_det_en_i,
  input  logic     pin_hi_i,
  input  logic     pin_mid_i,
  input  logic     pin_lloop_i,
  input  logic     nloop_flag_i,
  output lb_mode_e mode_o
);
  logic     cmd_remote, cmd_local, cmd_det_en, net_act;
  lb_mode_e mode_d, mode_q;

  assign cmd_remote = host_mode_i ? reg_rloop_en_i     : pin_hi_i;
  assign cmd_local  = host_mode_i ? reg_lloop_en_i     : pin_lloop_i;
  assign cmd_det_en = host_mode_i ? reg_nloop_det_en_i : pin_mid_i;
  // remote command overrides network loop
  assign net_act    = cmd_det_en & nloop_flag_i & ~cmd_remote;

  always_comb begin
    if ((cmd_remote | net_act) & cmd_local) mode_d = MODE_DUAL;
    else if (cmd_remote)                    mode_d = MODE_REMOTE;
    else if (net_act)                       mode_d = MODE_NETWORK;
    else if (cmd_local)                     mode_d = MODE_LOCAL;
    else                                    mode_d = MODE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_NONE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R2
  remote_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_remote |=> (mode_q == MODE_REMOTE || mode_q == MODE_DUAL));
  // R5
  no_net_without_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_det_en |=> (mode_q != MODE_NETWORK));
  // R8
  dual_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_remote && cmd_local) |=> (mode_q == MODE_DUAL));
endmodule

// File: rtl/lb_path_mux.sv
module lb_path_mux
  import lb_ctrl_pkg::*;
#(
  parameter int DATA_W = 2
) (
  input  lb_mode_e           mode_i,
  input  logic               tx_clk_i,
  input  logic [DATA_W-1:0]  tx_data_i,
  input  logic               rx_clk_i,
  input  logic [DATA_W-1:0]  rx_data_i,
  output logic               line_clk_o,
  output logic [DATA_W-1:0]  line_data_o,
  output logic               rx_clk_o,
  output logic [DATA_W-1:0]  rx_data_o,
  output logic               codec_bypass_o
);
  logic sel_line_rx, sel_rxo_tx;

  assign sel_line_rx    = is_remote_type(mode_i);
  assign sel_rxo_tx     = is_local_type(mode_i);
  assign codec_bypass_o = sel_line_rx;
  assign line_clk_o     = sel_line_rx ? rx_clk_i : tx_clk_i;
  assign rx_clk_o       = sel_rxo_tx  ? tx_clk_i : rx_clk_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    assign line_data_o[b] = sel_line_rx ? rx_data_i[b] : tx_data_i[b];
    assign rx_data_o[b]   = sel_rxo_tx  ? tx_data_i[b] : rx_data_i[b];
  end
endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_ctrl_pkg::*;
#(
  parameter int DATA_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_mode_i,
  input  logic              reg_rloop_en_i,
  input  logic              reg_lloop_en_i,
  input  logic              reg_nloop_det_en_i,
  input  logic [1:0]        pin_rloop_lvl_i,
  input  logic              pin_lloop_i,
  input  logic              nloop_flag_i,
  input  logic              tx_clk_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_clk_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              line_clk_o,
  output logic [DATA_W-1:0] line_data_o,
  output logic              rx_clk_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              codec_bypass_o,
  output logic [2:0]        mode_o
);
  logic     pin_hi, pin_mid;
  lb_mode_e mode;

  lb_pin_decode u_pin (
    .lvl_i (pin_rloop_lvl_i),
    .hi_o  (pin_hi),
    .mid_o (pin_mid)
  );

  lb_mode_sel u_sel (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .host_mode_i        (host_mode_i),
    .reg_rloop_en_i     (reg_rloop_en_i),
    .reg_lloop_en_i     (reg_lloop_en_i),
    .reg_nloop_det_en_i (reg_nloop_det_en_i),
    .pin_hi_i           (pin_hi),
    .pin_mid_i          (pin_mid),
    .pin_lloop_i        (pin_lloop_i),
    .nloop_flag_i       (nloop_flag_i),
    .mode_o             (mode)
  );

  lb_path_mux #(.DATA_W(DATA_W)) u_mux (
    .mode_i         (mode),
    .tx_clk_i       (tx_clk_i),
    .tx_data_i      (tx_data_i),
    .rx_clk_i       (rx_clk_i),
    .rx_data_i      (rx_data_i),
    .line_clk_o     (line_clk_o),
    .line_data_o    (line_data_o),
    .rx_clk_o       (rx_clk_o),
    .rx_data_o      (rx_data_o),
    .codec_bypass_o (codec_bypass_o)
  );

  assign mode_o = mode;

  // R6
  remote_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1 || mode_o == 3'd2) |-> (line_data_o == rx_data_i && codec_bypass_o));
  // R7
  rx_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o <= 3'd2) |-> (rx_data_o == rx_data_i));
  // R8
  dual_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |-> (rx_data_o == tx_data_i && line_data_o == rx_data_i));
endmodule

// File: tb/tb_lb_ctrl.sv
`timescale 1ns/1ps
module tb_lb_ctrl;
  localparam int DATA_W = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic host_mode_i = 1'b1, reg_rloop_en_i = 1'b0, reg_lloop_en_i = 1'b0, reg_nloop_det_en_i = 1'b0;
  logic [1:0] pin_rloop_lvl_i = 2'b00;
  logic pin_lloop_i = 1'b0, nloop_flag_i = 1'b0;
  logic tx_clk_i = 1'b0, rx_clk_i = 1'b1;
  logic [DATA_W-1:0] tx_data_i = 2'b01, rx_data_i = 2'b10;
  logic line_clk_o, rx_clk_o, codec_bypass_o;
  logic [DATA_W-1:0] line_data_o, rx_data_o;
  logic [2:0] mode_o;

  always #4 clk_i = ~clk_i;

  lb_ctrl #(.DATA_W(DATA_W)) dut (.*);

  typedef struct {
    logic [2:0]        mode;
    logic [DATA_W-1:0] ld;
    logic              lc;
    logic [DATA_W-1:0] rd;
    logic              rc;
    logic              byp;
    string             tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0;
  logic [2:0] prev_mode = 3'd0;
  bit done = 0;

  function automatic exp_t model(bit h, bit rr, bit rl, bit rn, logic [1:0] lvl, bit pl, bit nf,
                                 bit tc, logic [DATA_W-1:0] td, bit rc, logic [DATA_W-1:0] rd,
                                 string tag);
    exp_t e;
    bit rem, loc, nd, net, rt, lt;
    rem = h ? rr : (lvl == 2'b10);
    loc = h ? rl : pl;
    nd  = h ? rn : (lvl == 2'b01);
    net = nd & nf & ~rem;
    if ((rem | net) & loc) e.mode = 3'd4;
    else if (rem)          e.mode = 3'd1;
    else if (net)          e.mode = 3'd2;
    else if (loc)          e.mode = 3'd3;
    else                   e.mode = 3'd0;
    rt = (e.mode == 3'd1) || (e.mode == 3'd2) || (e.mode == 3'd4);
    lt = (e.mode == 3'd3) || (e.mode == 3'd4);
    e.ld  = rt ? rd : td;
    e.lc  = rt ? rc : tc;
    e.rd  = lt ? td : rd;
    e.rc  = lt ? tc : rc;
    e.byp = rt;
    e.tag = tag;
    return e;
  endfunction

  task automatic apply(bit h, bit rr, bit rl, bit rn, logic [1:0] lvl, bit pl, bit nf,
                       bit tc, logic [DATA_W-1:0] td, bit rc, logic [DATA_W-1:0] rd, string tag);
    @(negedge clk_i);
    #1;
    host_mode_i = h; reg_rloop_en_i = rr; reg_lloop_en_i = rl; reg_nloop_det_en_i = rn;
    pin_rloop_lvl_i = lvl; pin_lloop_i = pl; nloop_flag_i = nf;
    tx_clk_i = tc; tx_data_i = td; rx_clk_i = rc; rx_data_i = rd;
    #1;
    checks++;
    if (mode_o !== prev_mode) begin
      fails++;
      $display("FAIL R11 (%s): mode before edge act=%0d exp=%0d", tag, mode_o, prev_mode);
    end
    @(posedge clk_i);
    #1;
    sb.push_back(model(h, rr, rl, rn, lvl, pl, nf, tc, td, rc, rd, tag));
    prev_mode = sb[$].mode;
  endtask

  // monitor: compare at falling edge, after the mode register has settled
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (mode_o !== e.mode || line_data_o !== e.ld || line_clk_o !== e.lc ||
            rx_data_o !== e.rd || rx_clk_o !== e.rc || codec_bypass_o !== e.byp) begin
          fails++;
          $display("FAIL %s: act mode=%0d ld=%b lc=%b rd=%b rc=%b byp=%b exp mode=%0d ld=%b lc=%b rd=%b rc=%b byp=%b",
                   e.tag, mode_o, line_data_o, line_clk_o, rx_data_o, rx_clk_o, codec_bypass_o,
                   e.mode, e.ld, e.lc, e.rd, e.rc, e.byp);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with a remote command present
    reg_rloop_en_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    checks++;
    if (mode_o !== 3'd0 || codec_bypass_o !== 1'b0 || line_data_o !== tx_data_i ||
        line_clk_o !== tx_clk_i || rx_data_o !== rx_data_i || rx_clk_o !== rx_clk_i) begin
      fails++;
      $display("FAIL R1: act mode=%0d byp=%b ld=%b rd=%b exp mode=0 byp=0 ld=%b rd=%b",
               mode_o, codec_bypass_o, line_data_o, rx_data_o, tx_data_i, rx_data_i);
    end
    reg_rloop_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    //     h rr rl rn lvl   pl nf tc td     rc rd
    apply(1, 0, 0, 0, 2'b00, 0, 0, 0, 2'b01, 1, 2'b10, "R1 idle");
    apply(1, 1, 0, 0, 2'b00, 0, 0, 0, 2'b01, 1, 2'b10, "R2 host remote");
    apply(1, 1, 0, 0, 2'b00, 0, 0, 1, 2'b11, 1, 2'b10, "R6 tx ignored");
    apply(1, 1, 0, 0, 2'b00, 0, 0, 0, 2'b00, 0, 2'b01, "R7 rx follows");
    apply(1, 0, 0, 1, 2'b00, 0, 1, 0, 2'b01, 1, 2'b10, "R5 host network");
    apply(1, 0, 0, 0, 2'b00, 0, 1, 0, 2'b01, 1, 2'b10, "R5 det disabled");
    apply(1, 1, 0, 1, 2'b00, 0, 1, 0, 2'b01, 1, 2'b10, "R5 remote priority");
    apply(1, 1, 1, 0, 2'b00, 0, 0, 1, 2'b01, 0, 2'b10, "R8 host dual");
    apply(1, 0, 1, 1, 2'b00, 0, 1, 0, 2'b10, 1, 2'b01, "R8 network+local dual");
    apply(1, 0, 1, 0, 2'b00, 0, 0, 1, 2'b01, 0, 2'b10, "R9 local");
    apply(1, 0, 0, 0, 2'b10, 1, 0, 0, 2'b01, 1, 2'b10, "R10 pins ignored in host");
    apply(0, 0, 0, 0, 2'b10, 0, 0, 0, 2'b01, 1, 2'b10, "R3 pin high");
    apply(0, 0, 0, 0, 2'b00, 0, 0, 0, 2'b01, 1, 2'b10, "R3 pin low");
    apply(0, 1, 1, 1, 2'b00, 0, 1, 0, 2'b01, 1, 2'b10, "R10 regs ignored in hw");
    apply(0, 0, 0, 0, 2'b01, 0, 1, 1, 2'b11, 0, 2'b00, "R4 mid enables network");
    apply(0, 0, 0, 0, 2'b01, 0, 0, 0, 2'b01, 1, 2'b10, "R4 mid no remote");
    apply(0, 0, 0, 0, 2'b11, 0, 1, 0, 2'b01, 1, 2'b10, "R4 code 11 as low");
    apply(0, 0, 1, 0, 2'b10, 1, 0, 1, 2'b10, 0, 2'b01, "R8 pin dual");
    apply(0, 0, 1, 0, 2'b01, 1, 1, 0, 2'b11, 1, 2'b00, "R8 pin network+local");
    apply(0, 0, 0, 0, 2'b00, 1, 0, 1, 2'b10, 0, 2'b01, "R9 pin local");
    apply(0, 0, 0, 0, 2'b00, 0, 0, 0, 2'b01, 1, 2'b10, "R11 back to none");
    repeat (3) @(posedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule